// File: doc/BRIEF.md
# Walking-Zero Pin Test Sequencer

This block sits between a chip's functional core and its digital pads. It exists for board-level manufacturing test. In normal operation it is transparent: the core's output enables and output data pass straight to the pads.

Pulling the low-active test input low takes the pads away from the core and holds the core in reset. The test input is only honoured if the address-enable input is already low at that moment. While test mode lasts, the address-enable input is reused as a step clock. Each falling edge of the step clock moves a single driven-low pad one position along a configurable walking order that covers every output and bidirectional pad. This is the output phase. After the last pad, the next falling edge starts the input phase. In the input phase all pads float, and one input pad is shifted into a capture register per falling edge.

Every input is sampled on the rising edge of the system clock, and all state changes at that edge. The block has no flowing data stream, so all of its pins are plain level signals. There is no valid/ready handshake and no back-pressure. The capture register is a parallel snapshot that may be read at any time.

Top module: `wz_pin_test`

## Requirements
- R1: While `test_n` is high, `core_rst` is 0, `pad_oe` equals `func_oe` and `pad_do` equals `func_do`.
- R2: Test mode is entered only on the clock where `test_n` is sampled low after having been sampled high, and only if `aen` is sampled low on that same clock. If `aen` is high at that clock, the block stays in normal mode until `test_n` rises and falls again.
- R3: From entry until `test_n` is sampled high, `core_rst` is 1.
- R4: On entry, every `pad_oe` bit is 0 until the first falling step edge, and `pad_do` is all zeros throughout test mode.
- R5: A falling step edge is a clock where `aen` is sampled low after being sampled high. In the output phase each such edge advances the walk by exactly one pad. Exactly one `pad_oe` bit is then 1, and that pad drives 0.
- R6: The k-th falling edge (k = 1..NOUT) enables pad index (START + (k-1)*STRIDE) mod NOUT. With the defaults (NOUT=42, START=3, STRIDE=5) this visits all 42 pads once.
- R7: The falling edge after the NOUT-th edge enters the input phase. In the input phase `pad_oe` is all zeros.
- R8: In the input phase, the j-th falling edge after the phase change (j = 1..NIN) shifts `pad_di[j-1]` into bit 0 of `scan_data`, and earlier bits move up by one. After NIN samples `scan_done` is 1, and further edges change nothing.
- R9: Sampling `test_n` high returns the block to normal mode on that clock and clears the walk position and the capture. A later entry starts again from the first pad.
- R10: In normal mode `scan_data` is zero and `scan_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_n | input | 1 | Low-active test-mode request |
| aen | input | 1 | Address-enable pin, reused as the step clock in test mode |
| func_oe | input | NOUT | Output enables from the functional core |
| func_do | input | NOUT | Output data from the functional core |
| pad_di | input | NIN | Values read from the input and bidirectional pads |
| pad_oe | output | NOUT | Output enables to the pads |
| pad_do | output | NOUT | Output data to the pads |
| core_rst | output | 1 | Reset to the functional core while in test mode |
| scan_data | output | NIN | Input-phase capture register, newest sample in bit 0 |
| scan_done | output | 1 | All input pads captured |

## Verification
The hardest state to reach is the end of the input phase after a complete walk. It takes NOUT+1+NIN well-formed step edges, all with the entry condition met beforehand. The stimulus reaches it with a long run of step pulses after a clean entry. That run follows two shorter scenarios: a refused entry with `aen` high, and an aborted walk. The aborted walk shows that a re-entry restarts from the first pad rather than resuming. Random `pad_di` values on every clock show that only the value present at each falling edge is captured.

// File: rtl/wz_pkg.sv
package wz_pkg;
  typedef enum logic [1:0] {
    M_NORM = 2'd0,
    M_OUT  = 2'd1,
    M_IN   = 2'd2,
    M_DONE = 2'd3
  } wz_mode_e;

  // Pad index visited at walk position k (0-based)
  function automatic int unsigned walk_pin(input int unsigned k, input int unsigned start,
                                           input int unsigned stride, input int unsigned n);
    return (start + k * stride) % n;
  endfunction
endpackage

// File: rtl/wz_seq.sv
module wz_seq #(
  parameter int NOUT = 42,
  parameter int NIN  = 24,
  localparam int IW  = $clog2(NOUT + 1),
  localparam int JW  = $clog2(NIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_n,
  input  logic            aen,
  output wz_pkg::wz_mode_e mode,
  output logic [IW-1:0]   step,
  output logic            samp_en,
  output logic [JW-1:0]   samp_idx
);
  import wz_pkg::*;

  logic          aen_prev, test_prev, fall;
  logic [JW-1:0] icnt;

  assign fall     = aen_prev & ~aen;
  assign samp_en  = (mode == M_IN) && fall && !test_n;
  assign samp_idx = icnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_NORM;
      step      <= '0;
      icnt      <= '0;
      aen_prev  <= 1'b0;
      test_prev <= 1'b0;
    end else begin
      aen_prev  <= aen;
      test_prev <= test_n;
      if (test_n) begin
        mode <= M_NORM;
        step <= '0;
        icnt <= '0;
      end else begin
        unique case (mode)
          M_NORM: if (test_prev && !aen) begin
            mode <= M_OUT;
            step <= '0;
          end
          M_OUT: if (fall) begin
            if (step == IW'(NOUT)) begin
              mode <= M_IN;
              icnt <= '0;
            end else begin
              step <= step + 1'b1;
            end
          end
          M_IN: if (fall) begin
            icnt <= icnt + 1'b1;
            if (icnt == JW'(NIN - 1)) mode <= M_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_HIGH_TEST_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    test_n |=> (mode == M_NORM)); // R9
  AST_BLOCKED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && aen) |=> (mode == M_NORM)); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OUT && $past(mode) == M_OUT) |-> (step == $past(step) || step == $past(step) + 1'b1)); // R5
endmodule

// File: rtl/wz_drive.sv
module wz_drive #(
  parameter int NOUT   = 42,
  parameter int START  = 3,
  parameter int STRIDE = 5,
  localparam int IW    = $clog2(NOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wz_pkg::wz_mode_e mode,
  input  logic [IW-1:0]    step,
  input  logic [NOUT-1:0]  func_oe,
  input  logic [NOUT-1:0]  func_do,
  output logic [NOUT-1:0]  pad_oe,
  output logic [NOUT-1:0]  pad_do
);
  import wz_pkg::*;

  logic            walking;
  logic [NOUT-1:0] hit;
  int unsigned     cur_pin;

  assign walking = (mode == M_OUT) && (step != '0);

  always_comb begin
    cur_pin = 0;
    if (walking) cur_pin = walk_pin(int'(step) - 1, START, STRIDE, NOUT);
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_pin
    assign hit[i]    = walking && (cur_pin == i);
    assign pad_oe[i] = (mode == M_NORM) ? func_oe[i] : hit[i];
    assign pad_do[i] = (mode == M_NORM) ? func_do[i] : 1'b0;
  end

  AST_ONE_LOW_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_NORM) |-> ($countones(pad_oe) <= 1)); // R5
  AST_DRIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_NORM) |-> (pad_do == '0)); // R4
  AST_INPUT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IN || mode == M_DONE) |-> (pad_oe == '0)); // R7
endmodule

// File: rtl/wz_capture.sv
module wz_capture #(
  parameter int NIN = 24,
  localparam int JW = $clog2(NIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             samp_en,
  input  logic [JW-1:0]    samp_idx,
  input  logic [NIN-1:0]   pad_di,
  input  wz_pkg::wz_mode_e mode,
  output logic [NIN-1:0]   cap
);
  import wz_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap <= '0;
    else if (clr)     cap <= '0;
    else if (samp_en) cap <= {cap[NIN-2:0], pad_di[samp_idx]};
  end

  AST_CAP_CLEAR_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && $past(mode) == M_NORM) |-> (cap == '0)); // R10
  AST_CAP_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DONE && $past(mode) == M_DONE) |-> $stable(cap)); // R8
endmodule

// File: rtl/wz_pin_test.sv
module wz_pin_test #(
  parameter int NOUT   = 42,
  parameter int NIN    = 24,
  parameter int START  = 3,
  parameter int STRIDE = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_n,
  input  logic            aen,
  input  logic [NOUT-1:0] func_oe,
  input  logic [NOUT-1:0] func_do,
  input  logic [NIN-1:0]  pad_di,
  output logic [NOUT-1:0] pad_oe,
  output logic [NOUT-1:0] pad_do,
  output logic            core_rst,
  output logic [NIN-1:0]  scan_data,
  output logic            scan_done
);
  import wz_pkg::*;

  localparam int IW = $clog2(NOUT + 1);
  localparam int JW = $clog2(NIN + 1);

  wz_mode_e      mode;
  logic [IW-1:0] step;
  logic          samp_en;
  logic [JW-1:0] samp_idx;

  wz_seq #(.NOUT(NOUT), .NIN(NIN)) u_seq (
    .clk(clk), .rst_n(rst_n), .test_n(test_n), .aen(aen),
    .mode(mode), .step(step), .samp_en(samp_en), .samp_idx(samp_idx)
  );

  wz_drive #(.NOUT(NOUT), .START(START), .STRIDE(STRIDE)) u_drive (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step(step),
    .func_oe(func_oe), .func_do(func_do), .pad_oe(pad_oe), .pad_do(pad_do)
  );

  wz_capture #(.NIN(NIN)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(test_n), .samp_en(samp_en), .samp_idx(samp_idx),
    .pad_di(pad_di), .mode(mode), .cap(scan_data)
  );

  assign core_rst  = (mode != M_NORM);
  assign scan_done = (mode == M_DONE);

  AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && !test_n) |=> core_rst); // R3
endmodule

// File: tb/sim_wz_pin_test.sv
module sim_wz_pin_test;
  localparam int NOUT = 42, NIN = 24, START = 3, STRIDE = 5;

  logic clk = 1'b0, rst_n = 1'b0, test_n = 1'b1, aen = 1'b0;
  logic [NOUT-1:0] func_oe = '0, func_do = '0, pad_oe, pad_do;
  logic [NIN-1:0]  pad_di = '0, scan_data;
  logic core_rst, scan_done;

  int errors = 0, checks = 0;
  // behavioural reference state
  int mmode = 0, mstep = 0, micnt = 0;
  bit mprev_aen = 0, mprev_test = 0;
  bit mq[$];

  always #10 clk = ~clk;

  wz_pin_test u0 (.clk(clk), .rst_n(rst_n), .test_n(test_n), .aen(aen), .func_oe(func_oe),
    .func_do(func_do), .pad_di(pad_di), .pad_oe(pad_oe), .pad_do(pad_do), .core_rst(core_rst),
    .scan_data(scan_data), .scan_done(scan_done));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [NOUT-1:0] eoe, edo;
    logic [NIN-1:0] ecap;
    eoe = '0; edo = '0; ecap = '0;
    if (mmode == 0) begin eoe = func_oe; edo = func_do; end
    else if (mmode == 1 && mstep > 0) eoe[(START + (mstep - 1) * STRIDE) % NOUT] = 1'b1;
    foreach (mq[i]) ecap = {ecap[NIN-2:0], mq[i]};
    chk(mmode == 0 ? "R1 pad_oe" : (mmode == 1 ? "R6 pad_oe" : "R7 pad_oe"), 64'(pad_oe), 64'(eoe));
    chk(mmode == 0 ? "R1 pad_do" : "R4 pad_do", 64'(pad_do), 64'(edo));
    chk("R3 core_rst", 64'(core_rst), 64'(mmode != 0));
    chk(mmode == 0 ? "R10 scan_data" : "R8 scan_data", 64'(scan_data), 64'(ecap));
    chk("R8 scan_done", 64'(scan_done), 64'(mmode == 3));
  endtask

  // one clock: check outputs, apply new inputs, advance the reference to the next edge
  task automatic tick(input bit t, input bit a);
    bit fall;
    @(negedge clk);
    compare();
    test_n = t; aen = a;
    func_oe = {$urandom, $urandom}; func_do = {$urandom, $urandom}; pad_di = NIN'($urandom);
    fall = mprev_aen && !a;
    if (t) begin mmode = 0; mstep = 0; micnt = 0; mq.delete(); end
    else case (mmode)
      0: if (mprev_test && !a) begin mmode = 1; mstep = 0; end
      1: if (fall) begin if (mstep == NOUT) begin mmode = 2; micnt = 0; end else mstep++; end
      2: if (fall) begin
           mq.push_back(pad_di[micnt]); micnt++;
           if (micnt == NIN) mmode = 3;
         end
      default: ;
    endcase
    mprev_aen = a; mprev_test = t;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin tick(0, 1); tick(0, 1); tick(0, 0); tick(0, 0); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1/R10: normal operation
    repeat (6) tick(1, 0);
    // R2: refused entry, aen high when test_n falls
    tick(1, 1); tick(0, 1); pulses(4); tick(0, 0); tick(0, 0);
    // R4/R5/R6 then R9 abort
    tick(1, 0); tick(1, 0); tick(0, 0); repeat (3) tick(0, 0);
    pulses(10); tick(1, 0); tick(1, 0);
    // full walk, input phase, done, extra edges
    tick(0, 0); repeat (2) tick(0, 0);
    pulses(NOUT + 1 + NIN + 3);
    // R9: exit and R1 again
    tick(1, 1); repeat (4) tick(1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule